// File: doc/BRIEF.md
# Byte-Serial Transmitter with Clock Hold

The block shifts bytes out on a serial data line, most significant bit first, next to a shift clock. A one-byte holding register sits in front of the shift register, so the host can queue the next byte while the current one is still going out. The shift clock comes from one of two places. It can be made inside the block by a fixed divider of the system clock, and the block then drives it out. It can also come from outside, in which case its falling edges are synchronised and used as shift events.

The host uses a small register port:
- address 0 holds the byte to send;
- address 1 is control: bit 0 enables, bit 1 is an inhibit strobe, bit 2 selects the external clock;
- address 2 is status: bit 0 holding register empty, bit 1 transfer active, bit 2 byte shifting, bit 3 underrun error.

When the holding register runs dry, the two clock sources behave differently. With the internal clock, the block parks the clock high and waits for the next byte. With the external clock, it flags an underrun. There are two ways to stop. Clearing the enable bit lets the current byte finish first. The inhibit strobe stops at once and resets the state.

Top module: `ssx_tx`

## Requirements
- R1: After reset, status (address 2) reads 0x01: holding register empty, nothing active, no error. `sckOut`, `sdo` and `sckOe` are 1 and `irq` is 0.
- R2: A write to address 0 clears status bit 0, and reading address 0 returns the byte written.
- R3: Each byte leaves as 8 bits, most significant first. `sdo` changes only with a falling edge of the shift clock, so the value present at each rising edge is the bit being sent.
- R4: With the internal clock (control bit 2 = 0), `sckOe` is 1 and each phase of the shift clock lasts `DIV_HALF` system cycles. With the external clock, `sckOe` is 0 and `sckOut` stays 1.
- R5: A byte moves from the holding register to the shift register in these cases: with the internal clock, as soon as the block is enabled and the holding register is full; with the external clock, on the next synchronised falling edge of `sckIn`. That transfer sets status bits 0, 1 and 2 and raises `irq` for exactly one cycle.
- R6: A byte written while the previous one is shifting follows it with no gap: every rising-edge spacing stays 2*`DIV_HALF` cycles across the byte boundary.
- R7: With the internal clock, if the holding register is empty when a byte completes, the clock parks high and `sdo` parks high. Status then reads 0x03: active, not shifting.
- R8: A byte written during the parked state starts shifting (first clock fall) within 2*`DIV_HALF` system cycles of the write.
- R9: With the external clock, each synchronised falling edge of `sckIn` moves `sdo` to the next bit.
- R10: With the external clock, a falling edge that would begin a new byte while the holding register is empty sets status bit 3 and pulses `irq`. The error then persists and no further byte is loaded until an inhibit.
- R11: Clearing control bit 0 mid-byte lets that byte finish. After it, status bits 1 and 2 are 0, `sdo` and `sckOut` are 1, and any queued byte stays in the holding register unsent.
- R12: A control write with bit 1 set stops shifting in the next cycle with `sckOut` and `sdo` high. It clears the enable bit, sets status to 0x01 and makes address 0 read 0. The clock-select bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| sckIn | input | 1 | External shift clock |
| sckOut | output | 1 | Shift clock driven out in internal mode, high otherwise |
| sckOe | output | 1 | Output enable for the shift clock, 1 in internal mode |
| sdo | output | 1 | Serial data out, high when idle |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest situation to reach from the ports is the external-clock underrun. It needs the bench to act as the remote clock master, counting out exactly eight falling edges per byte. The bench then issues a ninth falling edge while the holding register is still empty. For a back-to-back run it instead refills the register between the eighth and the ninth edge. After the error, the bench writes a fresh byte and clocks a full byte more. It checks that nothing loads and that the line stays high. The internal clock is parked and resumed by writing at a chosen cycle and timing the next clock fall.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  // register addresses
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control bit positions
  localparam int CTRL_EN  = 0;
  localparam int CTRL_INH = 1;
  localparam int CTRL_EXT = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
  } ssx_strobe_t;
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic fallPulse
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  // older stage high, newer stage low: a falling edge has arrived
  assign fallPulse = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic        enIn,
  input  logic        extIn,
  input  logic        inhReq,
  input  logic        bufEmpty,
  input  logic        extFall,
  output ssx_strobe_t strobe,
  output logic        enable,
  output logic        extMode,
  output logic        busy,
  output logic        shifting,
  output logic        txErr,
  output logic        irq,
  output logic        sckInt
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int DIV_W = $clog2(DIV_HALF + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic divWrap, intFall, fallEvt, lastBit, atBoundary, startOk;
  logic doLoad, doErr, doShift, doStop;

  always_comb begin
    divWrap    = (divCnt == DIV_LAST);
    intFall    = !extMode && shifting && divWrap && sckInt;
    fallEvt    = extMode ? extFall : intFall;
    lastBit    = (bitCnt == LAST_BIT);
    // a new byte may begin: after the last bit, or at once when parked
    atBoundary = shifting ? (fallEvt && lastBit) : (extMode ? extFall : 1'b1);
    startOk    = enable && !txErr && atBoundary;
    doLoad     = startOk && !bufEmpty;
    doErr      = startOk && bufEmpty && extMode;
    doShift    = shifting && fallEvt && !lastBit;
    doStop     = shifting && fallEvt && lastBit && !doLoad;
  end

  always_comb begin
    strobe.load  = doLoad && !inhReq;
    strobe.shift = doShift && !inhReq;
    strobe.clear = inhReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      extMode  <= 1'b0;
      busy     <= 1'b0;
      shifting <= 1'b0;
      txErr    <= 1'b0;
      irq      <= 1'b0;
      sckInt   <= 1'b1;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (inhReq) begin
      enable   <= 1'b0;
      busy     <= 1'b0;
      shifting <= 1'b0;
      txErr    <= 1'b0;
      irq      <= 1'b0;
      sckInt   <= 1'b1;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else begin
      irq <= 1'b0;
      if (ctrlWr) begin
        enable  <= enIn;
        extMode <= extIn;
      end
      if (shifting && !extMode) begin
        divCnt <= divWrap ? '0 : divCnt + 1'b1;
        if (divWrap && !sckInt) sckInt <= 1'b1;
      end
      if (doShift) begin
        bitCnt <= bitCnt + 1'b1;
        if (!extMode) sckInt <= 1'b0;
      end
      if (doStop) begin
        shifting <= 1'b0;
        sckInt   <= 1'b1;
      end
      if (doErr) begin
        txErr <= 1'b1;
        irq   <= 1'b1;
      end
      if (doLoad) begin
        shifting <= 1'b1;
        busy     <= 1'b1;
        bitCnt   <= '0;
        divCnt   <= '0;
        sckInt   <= extMode;
        irq      <= 1'b1;
      end else if (!enable && (doStop || !shifting)) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssx_dp.sv
module ssx_dp
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] wrData,
  input  ssx_strobe_t       strobe,
  input  logic              shifting,
  output logic [DATA_W-1:0] txBuf,
  output logic              bufEmpty,
  output logic              sdo
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      shiftReg <= '0;
      bufEmpty <= 1'b1;
    end else if (strobe.clear) begin
      txBuf    <= '0;
      shiftReg <= '0;
      bufEmpty <= 1'b1;
    end else begin
      if (strobe.load)       shiftReg <= txBuf;
      else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      if (bufWr) begin
        txBuf    <= wrData;
        bufEmpty <= 1'b0;
      end else if (strobe.load) begin
        bufEmpty <= 1'b1;
      end
    end
  end

  assign sdo = shifting ? shiftReg[DATA_W-1] : 1'b1;
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
  import ssx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              sdo,
  output logic              irq
);
  localparam int STAT_W = 4;

  ssx_strobe_t strobe;
  logic bufWr, ctrlWr, inhReq, extFall;
  logic bufEmpty, enable, extMode, busy, shifting, txErr, sckInt;
  logic [DATA_W-1:0] txBuf;
  logic [STAT_W-1:0] status;

  assign bufWr  = regWr && (regAddr == ADDR_DATA);
  assign ctrlWr = regWr && (regAddr == ADDR_CTRL);
  assign inhReq = ctrlWr && regWdata[CTRL_INH];

  ssx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(sckIn), .fallPulse(extFall)
  );

  ssx_ctrl #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr),
    .enIn(regWdata[CTRL_EN]), .extIn(regWdata[CTRL_EXT]),
    .inhReq(inhReq), .bufEmpty(bufEmpty), .extFall(extFall),
    .strobe(strobe), .enable(enable), .extMode(extMode), .busy(busy),
    .shifting(shifting), .txErr(txErr), .irq(irq), .sckInt(sckInt)
  );

  ssx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .bufWr(bufWr), .wrData(regWdata),
    .strobe(strobe), .shifting(shifting), .txBuf(txBuf),
    .bufEmpty(bufEmpty), .sdo(sdo)
  );

  assign status = {txErr, shifting, busy, bufEmpty};
  assign sckOut = extMode ? 1'b1 : sckInt;
  assign sckOe  = !extMode;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_DATA: regRdata = txBuf;
      ADDR_CTRL: begin
        regRdata[CTRL_EN]  = enable;
        regRdata[CTRL_EXT] = extMode;
      end
      ADDR_STAT: regRdata[STAT_W-1:0] = status;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk (
  input logic clk,
  input logic rstN,
  input logic bufWr,
  input logic inhReq,
  input logic bufEmpty,
  input logic busy,
  input logic shifting,
  input logic txErr,
  input logic irq,
  input logic sckOut
);
  // R2
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWr |=> !bufEmpty);
  // R5
  load_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shifting) |-> irq);
  // R10
  err_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txErr) |-> irq);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !inhReq) |=> txErr);
  // R3
  fall_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sckOut) |-> shifting);
  // R11
  stop_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !shifting);
  // R12
  inhibit_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    inhReq |=> (bufEmpty && !busy && !shifting && !txErr));
endmodule

bind ssx_tx ssx_chk u_chk (
  .clk(clk), .rstN(rstN), .bufWr(bufWr), .inhReq(inhReq),
  .bufEmpty(bufEmpty), .busy(busy), .shifting(shifting),
  .txErr(txErr), .irq(irq), .sckOut(sckOut)
);

// File: tb/test_ssx_tx.sv
`timescale 1ns/1ps
module test_ssx_tx;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic sckIn = 1'b1;
  logic sckOut, sckOe, sdo, irq;

  int checks = 0;
  int errors = 0;

  ssx_tx #(.DATA_W(8), .DIV_HALF(HALF), .SYNC_STAGES(2)) i_ssx_tx (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .sdo(sdo), .irq(irq)
  );

  always #4 clk = ~clk;

  // monitor: sampled 2 ns after each rising clock edge
  int cyc = 0, rxBits = 0, rxCnt = 0, irqCnt = 0;
  int lastRise = 0, minGap = 999, maxGap = 0;
  logic prevSck = 1'b1;
  logic [7:0] rxShift = 8'd0;
  logic [7:0] rxBytes [0:15];

  always @(posedge clk) begin
    #2;
    cyc++;
    if (sckOe && !prevSck && sckOut) begin
      rxShift = {rxShift[6:0], sdo};
      if (rxBits > 0) begin
        if (cyc - lastRise < minGap) minGap = cyc - lastRise;
        if (cyc - lastRise > maxGap) maxGap = cyc - lastRise;
      end
      lastRise = cyc;
      rxBits++;
      if (rxBits % 8 == 0 && rxCnt < 16) begin
        rxBytes[rxCnt] = rxShift;
        rxCnt++;
      end
    end
    prevSck = sckOut;
    if (irq) irqCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clrMon();
    @(negedge clk);
    rxBits = 0; rxCnt = 0; irqCnt = 0; minGap = 999; maxGap = 0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitBytes(input int n);
    for (int i = 0; i < 3000 && rxCnt < n; i++) @(negedge clk);
  endtask

  task automatic extClocks(input int n, output logic [7:0] cap);
    cap = 8'd0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sckIn = 1'b0;
      repeat (7) @(negedge clk);
      cap = {cap[6:0], sdo};
      sckIn = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic tReset();
    logic [7:0] d;
    regRead(2'd2, d);
    chk("R1 status", d, 8'h01);
    chk("R1 pins", {sckOut, sdo, sckOe, irq}, 4'b1110);
  endtask

  task automatic tWrite();
    logic [7:0] d;
    regWrite(2'd0, 8'hA5);
    regRead(2'd2, d);
    chk("R2 empty cleared", d, 8'h00);
    regRead(2'd0, d);
    chk("R2 readback", d, 8'hA5);
  endtask

  task automatic tSingle();
    logic [7:0] d;
    int rises;
    clrMon();
    regWrite(2'd1, 8'h01);
    repeat (2) @(negedge clk);
    regRead(2'd2, d);
    chk("R5 load status", d, 8'h07);
    chk("R5 irq pulse", irqCnt, 1);
    waitBytes(1);
    chk("R3 msb first byte", rxBytes[0], 8'hA5);
    chk("R4 half period min", minGap, 2 * HALF);
    chk("R4 half period max", maxGap, 2 * HALF);
    repeat (HALF + 2) @(negedge clk);
    rises = rxBits;
    repeat (40) @(negedge clk);
    chk("R7 clock parked", {sckOut, sdo, sckOe}, 3'b111);
    chk("R7 no extra edges", rxBits, rises);
    regRead(2'd2, d);
    chk("R7 wait status", d, 8'h03);
  endtask

  task automatic tResume();
    int lat;
    clrMon();
    regWrite(2'd0, 8'h3C);
    lat = 1;
    while (sckOut && lat < 100) begin @(negedge clk); lat++; end
    chk("R8 resume latency", (lat <= 2 * HALF), 1);
    waitBytes(1);
    chk("R8 resumed byte", rxBytes[0], 8'h3C);
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic tBackToBack();
    clrMon();
    regWrite(2'd0, 8'h81);
    repeat (10) @(negedge clk);
    regWrite(2'd0, 8'h7E);
    waitBytes(2);
    chk("R6 first byte", rxBytes[0], 8'h81);
    chk("R6 second byte", rxBytes[1], 8'h7E);
    chk("R6 no gap", maxGap, 2 * HALF);
    chk("R6 irq count", irqCnt, 2);
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic tGraceful();
    logic [7:0] d;
    clrMon();
    regWrite(2'd0, 8'hF0);
    regWrite(2'd0, 8'h0F);
    regWrite(2'd1, 8'h00);
    waitBytes(1);
    repeat (40) @(negedge clk);
    chk("R11 byte finished", rxBytes[0], 8'hF0);
    chk("R11 nothing more", rxBits, 8);
    regRead(2'd2, d);
    chk("R11 status", d, 8'h00);
    chk("R11 lines high", {sckOut, sdo}, 2'b11);
    regRead(2'd0, d);
    chk("R11 queued kept", d, 8'h0F);
  endtask

  task automatic tInhibit();
    logic [7:0] d;
    int bits;
    clrMon();
    regWrite(2'd1, 8'h01);
    repeat (20) @(negedge clk);
    regWrite(2'd0, 8'h55);
    regWrite(2'd1, 8'h03);
    chk("R12 lines high", {sckOut, sdo}, 2'b11);
    regRead(2'd2, d);
    chk("R12 status", d, 8'h01);
    regRead(2'd1, d);
    chk("R12 enable cleared", d, 8'h00);
    regRead(2'd0, d);
    chk("R12 buffer cleared", d, 8'h00);
    bits = rxBits;
    repeat (40) @(negedge clk);
    chk("R12 stopped", rxBits, bits);
  endtask

  task automatic tExternal();
    logic [7:0] d, cap;
    clrMon();
    regWrite(2'd1, 8'h04);
    chk("R4 ext oe", {sckOe, sckOut}, 2'b01);
    regWrite(2'd0, 8'hC3);
    regWrite(2'd1, 8'h05);
    extClocks(8, cap);
    chk("R9 ext byte one", cap, 8'hC3);
    chk("R4 ext clock idle", sckOut, 1'b1);
    regWrite(2'd0, 8'h5A);
    extClocks(8, cap);
    chk("R9 ext byte two", cap, 8'h5A);
    regRead(2'd2, d);
    chk("R10 no error yet", d[3], 1'b0);
    extClocks(1, cap);
    regRead(2'd2, d);
    chk("R10 underrun status", d, 8'h0B);
    chk("R10 irq count", irqCnt, 3);
    chk("R10 line high", sdo, 1'b1);
    regWrite(2'd0, 8'h11);
    extClocks(9, cap);
    chk("R10 no load after error", cap, 8'hFF);
    regRead(2'd2, d);
    chk("R10 sticky", d, 8'h0A);
    regWrite(2'd1, 8'h06);
    regRead(2'd2, d);
    chk("R12 error cleared", d, 8'h01);
    regRead(2'd1, d);
    chk("R12 mode kept", d, 8'h04);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tWrite();
    tSingle();
    tResume();
    tBackToBack();
    tGraceful();
    tInhibit();
    tExternal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule